// File: doc/BRIEF.md
# Resettable Divide-by-32 Prescaler with Clock Timer

This block turns a slow reference signal into a steady timebase. It samples one of two slow source inputs into the system clock domain and counts its rising edges. Every 32 edges it emits a one-cycle count tick. A down-counting timer consumes that tick when it is set to event-count mode and its run flag is high. When the count passes zero, the timer reloads and raises a one-cycle underflow pulse. Used this way, the timer works as a clock timer.

Software can restart the prescaler by writing a control word whose bit 7 is 1. The write is a strobe and nothing is stored. The first tick after such a restart arrives one source edge early, after 31 edges, so that the tick phase lines up with the write. Every later tick follows the normal 32-edge spacing.

Top module: `presc_clock_timer`

## Requirements
- R1: After reset, `timer_value` is 0 and `underflow` is 0. The prescaler phase is zero, so the first tick comes on the 32nd counted source edge.
- R2: Source choice works as follows. With `sub_clk_en`=1, rising edges of `sub_clk_in` are counted. With `sub_clk_en`=0 and `main_src_sel`=1, rising edges of `main_clk_in` are counted. With both at 0, no edges are counted. The unselected input has no effect.
- R3: Between two ticks with no restart in between, exactly 32 rising edges of the selected source are counted. Each source input passes through a two-flop synchronizer before its edges are detected.
- R4: A control write (`ctl_wr`=1) with `ctl_wdata[7]`=1 restarts the prescaler. The next tick comes on the 31st counted edge after the write, and later ticks come every 32 edges. An edge in the same cycle as the restart is not counted and gives no tick.
- R5: A control write with `ctl_wdata[7]`=0 has no effect on the prescaler phase or on the timer.
- R6: A tick decrements the timer only while `event_mode`=1 and `count_run`=1. In any other mode, ticks leave the timer unchanged.
- R7: While `count_run`=0, the timer holds its value, but the prescaler keeps counting source edges.
- R8: A reload write (`reload_wr`=1) always stores `reload_data` as the reload value. While `count_run`=0, it also loads the timer in the next cycle. While `count_run`=1, it does not change the timer directly.
- R9: A counting tick when the timer is at 0 loads the reload value into the timer and drives `underflow` high for exactly one cycle. The reload value includes a reload write made in that same cycle.
- R10: The timer value changes only in the cycle after a counting tick or after a reload write made while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_clk_in | input | 1 | Slow sub-clock source signal, asynchronous |
| main_clk_in | input | 1 | Main-clock-derived source signal, asynchronous |
| sub_clk_en | input | 1 | 1 selects the sub-clock as the prescaler source |
| main_src_sel | input | 1 | With the sub-clock off, 1 selects the main source |
| event_mode | input | 1 | 1 places the timer in event-count mode |
| count_run | input | 1 | Count-start flag |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; bit 7 = 1 restarts the prescaler |
| reload_wr | input | 1 | Reload value write strobe |
| reload_data | input | 16 | Reload value |
| timer_value | output | 16 | Current timer count |
| underflow | output | 1 | One-cycle pulse on timer underflow |

## Verification
The assertions assume two things about the source signals. Each level must be held for at least two system clocks, so that every rising edge is seen once by the synchronizer. The selected source must be low when the selection changes, so that switching does not look like an edge. The bench holds every source level for four cycles and ends each burst of edges with the line low. It changes `sub_clk_en` and `main_src_sel` only while both sources are low. Under these conditions, the edge-counting checker can predict the 31-edge and 32-edge tick spacing exactly.

// File: rtl/presc_timer_pkg.sv
// Package: shared types and constants for the prescaler / clock timer.
// Assumes: nothing beyond IEEE 1800-2017.
package presc_timer_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SUB  = 2'd1,
        SRC_MAIN = 2'd2
    } src_sel_e;

    localparam int CTL_W       = 8;
    localparam int CTL_CLR_BIT = 7;
endpackage

// File: rtl/presc_src_sync.sv
// Module: selects one slow source, synchronizes it with a two-flop
// chain and emits a one-cycle pulse per rising edge.
// Assumes: each source level lasts at least two clk cycles; the selected
// source is low whenever the selection changes.
module presc_src_sync
    import presc_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sub_in,
    input  logic     main_in,
    input  src_sel_e sel,
    output logic     edge_pulse
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic               raw_src;
    logic [CHAIN_W-1:0] chain_q;

    // Purpose: pick the raw source per the selection.
    always_comb begin
        unique case (sel)
            SRC_SUB:  raw_src = sub_in;
            SRC_MAIN: raw_src = main_in;
            default:  raw_src = 1'b0;
        endcase
    end

    // Purpose: synchronizer chain plus one history stage for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-2:0], raw_src};
    end

    // Purpose: rising edge of the synchronized source.
    always_comb edge_pulse = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
endmodule

// File: rtl/presc_divider.sv
// Module: divide-by-DIV edge counter with a software restart that makes
// the first period after the restart one edge short.
// Assumes: edge_in is a one-cycle pulse.
module presc_divider #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_in,
    input  logic restart,
    output logic tick
);
    localparam int                PW       = $clog2(DIV);
    localparam logic [PW-1:0]     PH_LAST  = PW'(DIV - 1);
    localparam logic [PW-1:0]     PH_AFTER = PW'(1);

    logic [PW-1:0] phase_q;

    // Purpose: tick on the last phase edge unless a restart coincides.
    always_comb tick = edge_in && !restart && (phase_q == PH_LAST);

    // Purpose: advance the phase per edge; a restart skips phase zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= PH_AFTER;
        else if (edge_in) phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + PW'(1);
    end
endmodule

// File: rtl/presc_down_timer.sv
// Module: event-count down timer with reload and underflow pulse.
// Assumes: tick is a one-cycle pulse separated by several idle cycles.
module presc_down_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          event_mode,
    input  logic          count_run,
    input  logic          reload_wr,
    input  logic [TW-1:0] reload_data,
    output logic [TW-1:0] value,
    output logic [TW-1:0] reload_val,
    output logic          underflow
);
    logic [TW-1:0] next_reload;
    logic          count_en;

    // Purpose: reload source includes a same-cycle write.
    always_comb next_reload = reload_wr ? reload_data : reload_val;
    // Purpose: a tick counts only in event mode with run set.
    always_comb count_en = tick && event_mode && count_run;

    // Purpose: reload register, counter and underflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value      <= '0;
            reload_val <= '0;
            underflow  <= 1'b0;
        end else begin
            underflow <= 1'b0;
            if (reload_wr) reload_val <= reload_data;
            if (!count_run && reload_wr) begin
                value <= reload_data;
            end else if (count_en) begin
                if (value == '0) begin
                    value     <= next_reload;
                    underflow <= 1'b1;
                end else begin
                    value <= value - TW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/presc_clock_timer.sv
// Module (top): resettable prescaler feeding a clock timer.
// Assumes: source inputs are slow (levels >= 2 clk) and low on selection change.
module presc_clock_timer
    import presc_timer_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int DIV   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sub_clk_in,
    input  logic             main_clk_in,
    input  logic             sub_clk_en,
    input  logic             main_src_sel,
    input  logic             event_mode,
    input  logic             count_run,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    input  logic             reload_wr,
    input  logic [TMR_W-1:0] reload_data,
    output logic [TMR_W-1:0] timer_value,
    output logic             underflow
);
    src_sel_e         src_sel;
    logic             src_edge;
    logic             presc_clr;
    logic             tick;
    logic [TMR_W-1:0] reload_val;

    // Purpose: decode the source choice; the sub-clock has priority.
    always_comb begin
        if (sub_clk_en)        src_sel = SRC_SUB;
        else if (main_src_sel) src_sel = SRC_MAIN;
        else                   src_sel = SRC_NONE;
    end

    // Purpose: the restart is a write strobe only, nothing is stored.
    always_comb presc_clr = ctl_wr && ctl_wdata[CTL_CLR_BIT];

    presc_src_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .sub_in(sub_clk_in), .main_in(main_clk_in),
        .sel(src_sel), .edge_pulse(src_edge)
    );

    presc_divider #(.DIV(DIV)) u_div (
        .clk(clk), .rst_n(rst_n), .edge_in(src_edge), .restart(presc_clr), .tick(tick)
    );

    presc_down_timer #(.TW(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .event_mode(event_mode),
        .count_run(count_run), .reload_wr(reload_wr), .reload_data(reload_data),
        .value(timer_value), .reload_val(reload_val), .underflow(underflow)
    );
endmodule

// File: rtl/presc_clock_timer_chk.sv
// Checker: temporal properties of the prescaler / clock timer, bound to the top.
// Assumes: the source conditions stated in the top header.
module presc_clock_timer_chk #(
    parameter int TMR_W = 16,
    parameter int DIV   = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             src_edge,
    input logic             presc_clr,
    input logic             tick,
    input logic             event_mode,
    input logic             count_run,
    input logic             reload_wr,
    input logic [TMR_W-1:0] reload_val,
    input logic [TMR_W-1:0] timer_value,
    input logic             underflow
);
    int   edges_q;
    logic after_clr_q;

    // Purpose: count edges since the last tick or restart and check spacing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edges_q     <= 0;
            after_clr_q <= 1'b0;
        end else if (presc_clr) begin
            edges_q     <= 0;
            after_clr_q <= 1'b1;
        end else if (src_edge) begin
            if (tick) begin
                p_tick_spacing_r3_r4: assert ((edges_q + 1) == (after_clr_q ? DIV - 1 : DIV))
                    else $error("tick after %0d edges", edges_q + 1);
                edges_q     <= 0;
                after_clr_q <= 1'b0;
            end else begin
                edges_q <= edges_q + 1;
            end
        end
    end

    p_tick_on_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> src_edge);

    p_clr_masks_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        presc_clr |-> !tick);

    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_run && !reload_wr) |=> $stable(timer_value));

    p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && event_mode && count_run && timer_value != '0) |=>
            (timer_value == $past(timer_value) - TMR_W'(1)));

    p_uf_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (timer_value == reload_val));

    p_uf_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> !underflow);

    p_change_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && event_mode && count_run) && !(reload_wr && !count_run) |=> $stable(timer_value));
endmodule

bind presc_clock_timer presc_clock_timer_chk #(.TMR_W(TMR_W), .DIV(DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_edge(src_edge), .presc_clr(presc_clr), .tick(tick),
    .event_mode(event_mode), .count_run(count_run), .reload_wr(reload_wr),
    .reload_val(reload_val), .timer_value(timer_value), .underflow(underflow)
);

// File: tb/presc_clock_timer_tb_top.sv
// Bench: directed scenarios, one task each, with self-checking counters.
module presc_clock_timer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sub_clk_in = 1'b0, main_clk_in = 1'b0;
    logic          sub_clk_en = 1'b0, main_src_sel = 1'b0;
    logic          event_mode = 1'b0, count_run = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [7:0]    ctl_wdata = '0;
    logic          reload_wr = 1'b0;
    logic [TW-1:0] reload_data = '0;
    logic [TW-1:0] timer_value;
    logic          underflow;

    int checks = 0, errors = 0, uf_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    presc_clock_timer dut_i (
        .clk(clk), .rst_n(rst_n), .sub_clk_in(sub_clk_in), .main_clk_in(main_clk_in),
        .sub_clk_en(sub_clk_en), .main_src_sel(main_src_sel), .event_mode(event_mode),
        .count_run(count_run), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .reload_wr(reload_wr), .reload_data(reload_data),
        .timer_value(timer_value), .underflow(underflow)
    );

    always @(posedge clk) if (rst_n && underflow) uf_seen <= uf_seen + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // rising edges on one source: 0 = sub, 1 = main
    task automatic pulses(input int n, input bit on_main);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (on_main) main_clk_in = 1'b1; else sub_clk_in = 1'b1;
            idle(4);
            if (on_main) main_clk_in = 1'b0; else sub_clk_in = 1'b0;
            idle(3);
        end
        idle(6);
    endtask

    task automatic ctl_write(input logic [7:0] d);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic reload_write(input int d);
        @(negedge clk); reload_wr = 1'b1; reload_data = TW'(d);
        @(negedge clk); reload_wr = 1'b0;
        idle(1);
    endtask

    task automatic t_reset;
        check("R1 value", int'(timer_value), 0);
        check("R1 underflow", int'(underflow), 0);
    endtask

    task automatic t_load_and_divide;
        sub_clk_en = 1'b1; event_mode = 1'b1;
        reload_write(10);
        check("R8 load while stopped", int'(timer_value), 10);
        count_run = 1'b1;
        pulses(31, 0);
        check("R1 R3 no tick at 31 edges", int'(timer_value), 10);
        pulses(1, 0);
        check("R3 tick at 32nd edge", int'(timer_value), 9);
        pulses(64, 0);
        check("R3 two more periods", int'(timer_value), 7);
    endtask

    task automatic t_restart;
        ctl_write(8'h80);
        pulses(30, 0);
        check("R4 no tick at 30 after restart", int'(timer_value), 7);
        pulses(1, 0);
        check("R4 tick at 31 after restart", int'(timer_value), 6);
        pulses(31, 0);
        check("R4 later period not short", int'(timer_value), 6);
        pulses(1, 0);
        check("R4 later period 32", int'(timer_value), 5);
    endtask

    task automatic t_no_restart;
        ctl_write(8'h7F);
        check("R5 write without bit7 leaves timer", int'(timer_value), 5);
        pulses(31, 0);
        check("R5 phase kept", int'(timer_value), 5);
        pulses(1, 0);
        check("R5 tick at 32", int'(timer_value), 4);
    endtask

    task automatic t_sources;
        sub_clk_en = 1'b0; main_src_sel = 1'b1;
        ctl_write(8'h80);
        pulses(64, 0);
        check("R2 sub ignored when main chosen", int'(timer_value), 4);
        pulses(31, 1);
        check("R2 main source counted", int'(timer_value), 3);
        main_src_sel = 1'b0;
        pulses(64, 1);
        pulses(64, 0);
        check("R2 no source selected", int'(timer_value), 3);
        sub_clk_en = 1'b1;
    endtask

    task automatic t_mode_and_run;
        ctl_write(8'h80);
        event_mode = 1'b0;
        pulses(31, 0);
        check("R6 tick ignored outside event mode", int'(timer_value), 3);
        event_mode = 1'b1;
        count_run = 1'b0;
        ctl_write(8'h80);
        pulses(20, 0);
        check("R7 frozen while stopped", int'(timer_value), 3);
        count_run = 1'b1;
        pulses(11, 0);
        check("R7 prescaler kept running", int'(timer_value), 2);
    endtask

    task automatic t_underflow;
        int base;
        pulses(32, 0);
        check("R6 count to 1", int'(timer_value), 1);
        reload_write(5);
        check("R8 running write leaves timer", int'(timer_value), 1);
        pulses(32, 0);
        check("R6 count to 0", int'(timer_value), 0);
        base = uf_seen;
        check("R9 no underflow yet", base, 0);
        pulses(32, 0);
        check("R9 reload on underflow", int'(timer_value), 5);
        check("R9 single underflow pulse", uf_seen - base, 1);
        check("R9 pulse ended", int'(underflow), 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_load_and_divide();
        t_restart();
        t_no_restart();
        t_sources();
        t_mode_and_run();
        t_underflow();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule